// File: doc/BRIEF.md
# Address-Register-Triggered Load/Store Unit

This block holds the architectural register state of a load/store machine with three register classes: eight 60-bit operand registers (X0..X7), eight 18-bit address registers (A0..A7) and eight 18-bit index registers (B0..B7). It takes one 30-bit instruction per cycle over a valid/ready pair. It decodes the instruction, computes the result with a single adder/logic stage, and writes the destination register.

Memory is never named by an instruction. Any write to an address register A1..A7 starts a transfer whose address is the new 18-bit register value. For A1..A5 the transfer is a load that fills the operand register with the same index. For A6 and A7 it is a store of the operand register with the same index. A0 is a plain register. One transfer is in flight at a time. An instruction that touches the pending operand register stalls until the transfer ends, and so does one that would start a second transfer. Unrelated instructions keep flowing.

The transfer sequencer is a three-state machine:
- ST_IDLE: no transfer.
- ST_ISSUE: the request cycle.
- ST_WAIT: waiting for read data.

Its transitions are:
- T_START (ST_IDLE to ST_ISSUE): an accepted write to A1..A7.
- T_LOAD (ST_ISSUE to ST_WAIT): the transfer is a load.
- T_STORE_DONE (ST_ISSUE to ST_IDLE): the transfer is a store.
- T_FILL (ST_WAIT to ST_IDLE): `mem_rvalid` arrives.
- T_HOLD (ST_WAIT to ST_WAIT): no read data yet.

Top module: `ldst_regunit`

## Requirements
- R1: After reset every register of all three classes is zero, `busy` and `mem_req` are low and `instr_ready` is high.
- R2: Instruction word: bits 29:24 opcode, 23:21 i, 20:18 j, 17:15 k (short forms), 17:0 displacement (long forms). Short operand opcodes compute Xi from Xj and Xk modulo 2^60: 0x01 add, 0x02 subtract, 0x03 AND, 0x04 XOR.
- R3: Long opcodes compute modulo 2^18: 0x21 Ai = Aj + disp, 0x22 Ai = Bj + disp, 0x23 Bi = Bj + disp. Opcode 0x24 sets Xi to the zero-extended displacement.
- R4: A write to Ai with i in 1..5 drives `mem_req`=1, `mem_we`=0 and `mem_addr` equal to the new Ai value in the cycle after the instruction is accepted.
- R5: The 60-bit `mem_rdata` presented with `mem_rvalid` is written into Xi of the pending load. A later read of Xi returns it.
- R6: A write to A6 or A7 drives `mem_req`=1, `mem_we`=1, `mem_addr` equal to the new A value and `mem_wdata` equal to X6 or X7, in the cycle after acceptance. `busy` falls one cycle later.
- R7: A write to A0 never raises `mem_req`.
- R8: B0 always reads as zero, and writes to it are ignored.
- R9: `busy` is high from the request cycle until the transfer ends. While it is high, `instr_ready` is low for any instruction that reads or writes the pending X register, or that writes A1..A7. Other instructions are accepted without delay.
- R10: Any opcode not listed in R2, R3 or R11 changes no register and starts no transfer.
- R11: Short index opcodes compute modulo 2^18: 0x05 Ai = Aj + Bk, 0x06 Bi = Bj + Bk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented |
| instr_word | input | 30 | Instruction word |
| instr_ready | output | 1 | Instruction accepted this cycle when valid |
| busy | output | 1 | A memory transfer is pending |
| mem_req | output | 1 | Memory request strobe, one cycle |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 18 | Word address of the request |
| mem_wdata | output | 60 | Store data |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the load request |
| mem_rdata | input | 60 | Read data |

## Verification
The operand operations are tried with values that carry out of bit 17 and with a subtraction that goes below zero. This separates true 60-bit arithmetic from a truncated datapath. Address and index sums are driven past 2^18 so that a missing wrap shows up in the store address. Loads are followed at once by readers of the filled register, by unrelated instructions and by a second trigger. This tells correct hazard stalling apart from both over-stalling and missed stalls. Writes to A0 and B0 and an undefined opcode are each followed by a store that exposes any effect they could have had.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int DATA_W  = 60;
    localparam int ADDR_W  = 18;
    localparam int NREG    = 8;
    localparam int IDX_W   = $clog2(NREG);
    localparam int OP_W    = 6;
    localparam int INSTR_W = OP_W + 2 * IDX_W + ADDR_W;
    localparam int LOAD_HI = 5;   // A1..LOAD_HI load, above store

    localparam logic [OP_W-1:0] OP_XADD = 6'h01;
    localparam logic [OP_W-1:0] OP_XSUB = 6'h02;
    localparam logic [OP_W-1:0] OP_XAND = 6'h03;
    localparam logic [OP_W-1:0] OP_XXOR = 6'h04;
    localparam logic [OP_W-1:0] OP_AIDX = 6'h05;
    localparam logic [OP_W-1:0] OP_BIDX = 6'h06;
    localparam logic [OP_W-1:0] OP_AOFS = 6'h21;
    localparam logic [OP_W-1:0] OP_ABAS = 6'h22;
    localparam logic [OP_W-1:0] OP_BOFS = 6'h23;
    localparam logic [OP_W-1:0] OP_XLIT = 6'h24;

    typedef enum logic [1:0] {RC_NONE, RC_X, RC_A, RC_B} rcls_e;
    typedef enum logic [1:0] {BS_ZERO, BS_X, BS_B, BS_DISP} bsel_e;
    typedef enum logic [1:0] {AL_ADD, AL_SUB, AL_AND, AL_XOR} alu_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} xst_e;

    typedef struct packed {
        rcls_e              dst_cls;
        logic [IDX_W-1:0]   dst;
        rcls_e              a_cls;
        logic [IDX_W-1:0]   a_idx;
        bsel_e              b_sel;
        logic [IDX_W-1:0]   b_idx;
        alu_e               alu;
        logic [ADDR_W-1:0]  disp;
    } dec_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);

    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] fi, fj, fk;

    assign op = word[INSTR_W-1 -: OP_W];
    assign fi = word[INSTR_W-OP_W-1 -: IDX_W];
    assign fj = word[INSTR_W-OP_W-IDX_W-1 -: IDX_W];
    assign fk = word[ADDR_W-1 -: IDX_W];

    always_comb begin
        dec.dst_cls = RC_NONE;
        dec.dst     = fi;
        dec.a_cls   = RC_NONE;
        dec.a_idx   = fj;
        dec.b_sel   = BS_ZERO;
        dec.b_idx   = fk;
        dec.alu     = AL_ADD;
        dec.disp    = word[ADDR_W-1:0];
        case (op)
            OP_XADD, OP_XSUB, OP_XAND, OP_XXOR: begin
                dec.dst_cls = RC_X;
                dec.a_cls   = RC_X;
                dec.b_sel   = BS_X;
                case (op)
                    OP_XSUB: dec.alu = AL_SUB;
                    OP_XAND: dec.alu = AL_AND;
                    OP_XXOR: dec.alu = AL_XOR;
                    default: dec.alu = AL_ADD;
                endcase
            end
            OP_AIDX: begin
                dec.dst_cls = RC_A;
                dec.a_cls   = RC_A;
                dec.b_sel   = BS_B;
            end
            OP_BIDX: begin
                dec.dst_cls = RC_B;
                dec.a_cls   = RC_B;
                dec.b_sel   = BS_B;
            end
            OP_AOFS: begin
                dec.dst_cls = RC_A;
                dec.a_cls   = RC_A;
                dec.b_sel   = BS_DISP;
            end
            OP_ABAS: begin
                dec.dst_cls = RC_A;
                dec.a_cls   = RC_B;
                dec.b_sel   = BS_DISP;
            end
            OP_BOFS: begin
                dec.dst_cls = RC_B;
                dec.a_cls   = RC_B;
                dec.b_sel   = BS_DISP;
            end
            OP_XLIT: begin
                dec.dst_cls = RC_X;
                dec.b_sel   = BS_DISP;
            end
            default: begin
                dec.dst_cls = RC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/ldst_bank.sv
module ldst_bank #(
    parameter int W     = 60,
    parameter int N     = 8,
    parameter int NRD   = 1,
    parameter int NWR   = 1,
    parameter bit ZERO0 = 1'b0,
    localparam int IW   = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][IW-1:0]  rd_idx,
    output logic [NRD-1:0][W-1:0]   rd_data,
    input  logic [NWR-1:0]          wr_en,
    input  logic [NWR-1:0][IW-1:0]  wr_idx,
    input  logic [NWR-1:0][W-1:0]   wr_data
);

    logic [N-1:0][W-1:0] cells;

    for (genvar g = 0; g < N; g++) begin : g_cell
        if (ZERO0 && g == 0) begin : g_zero
            assign cells[g] = '0;
        end else begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    for (int p = 0; p < NWR; p++) begin
                        if (wr_en[p] && wr_idx[p] == IW'(g)) begin
                            q <= wr_data[p];
                        end
                    end
                end
            end
            assign cells[g] = q;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = cells[rd_idx[r]];
    end

    if (NWR > 1) begin : g_clash
        // R5
        wport_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en[0] && wr_en[1] && wr_idx[0] == wr_idx[1]));
    end

endmodule

// File: rtl/ldst_xfer_fsm.sv
module ldst_xfer_fsm
    import ldst_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_load,
    input  logic [IW-1:0] start_idx,
    input  logic [AW-1:0] start_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic [IW-1:0] pend_idx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          fill_we,
    output logic [IW-1:0] fill_idx,
    output logic [DW-1:0] fill_data
);

    xst_e          state, nxt;
    logic          pend_load;
    logic [AW-1:0] pend_addr;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_ISSUE;                    // T_START
            ST_ISSUE: nxt = pend_load ? ST_WAIT : ST_IDLE;          // T_LOAD / T_STORE_DONE
            ST_WAIT:  nxt = mem_rvalid ? ST_IDLE : ST_WAIT;         // T_FILL / T_HOLD
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_load <= 1'b0;
            pend_idx  <= '0;
            pend_addr <= '0;
        end else if (state == ST_IDLE && start) begin
            pend_load <= start_load;
            pend_idx  <= start_idx;
            pend_addr <= start_addr;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_ISSUE);
        mem_we    = (state == ST_ISSUE) && !pend_load;
        mem_addr  = pend_addr;
        fill_we   = (state == ST_WAIT) && mem_rvalid;
        fill_idx  = pend_idx;
        fill_data = mem_rdata;
    end

    // R4
    load_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_load && !busy) |=> (mem_req && !mem_we && mem_addr == $past(start_addr)));
    // R6
    store_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !start_load && !busy) |=> (mem_req && mem_we));
    // R6
    store_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !busy);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req && !mem_rvalid) |=> busy);

endmodule

// File: rtl/ldst_regunit.sv
module ldst_regunit
    import ldst_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int N  = NREG,
    parameter int IW_ = INSTR_W,
    localparam int XW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           instr_valid,
    input  logic [IW_-1:0] instr_word,
    output logic           instr_ready,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata
);

    dec_t          dec;
    logic          accept, trig, hazard, start, start_load;
    logic [XW-1:0] pend_idx, fill_idx;
    logic          fill_we;
    logic [DW-1:0] fill_data;
    logic [DW-1:0] xj, xk, xs, opa, opb, res;
    logic [AW-1:0] aj, bj, bk;
    logic          x_we, a_we, b_we;

    ldst_decode u_dec (.word(instr_word), .dec(dec));

    ldst_bank #(.W(DW), .N(N), .NRD(3), .NWR(2), .ZERO0(1'b0)) u_xbank (
        .clk, .rst_n,
        .rd_idx ({pend_idx, dec.b_idx, dec.a_idx}),
        .rd_data({xs, xk, xj}),
        .wr_en  ({fill_we, x_we}),
        .wr_idx ({fill_idx, dec.dst}),
        .wr_data({fill_data, res})
    );

    ldst_bank #(.W(AW), .N(N), .NRD(1), .NWR(1), .ZERO0(1'b0)) u_abank (
        .clk, .rst_n,
        .rd_idx (dec.a_idx),
        .rd_data(aj),
        .wr_en  (a_we),
        .wr_idx (dec.dst),
        .wr_data(res[AW-1:0])
    );

    ldst_bank #(.W(AW), .N(N), .NRD(2), .NWR(1), .ZERO0(1'b1)) u_bbank (
        .clk, .rst_n,
        .rd_idx ({dec.b_idx, dec.a_idx}),
        .rd_data({bk, bj}),
        .wr_en  (b_we),
        .wr_idx (dec.dst),
        .wr_data(res[AW-1:0])
    );

    always_comb begin
        unique case (dec.a_cls)
            RC_X:    opa = xj;
            RC_A:    opa = DW'(aj);
            RC_B:    opa = DW'(bj);
            default: opa = '0;
        endcase
        unique case (dec.b_sel)
            BS_X:    opb = xk;
            BS_B:    opb = DW'(bk);
            BS_DISP: opb = DW'(dec.disp);
            default: opb = '0;
        endcase
        unique case (dec.alu)
            AL_SUB:  res = opa - opb;
            AL_AND:  res = opa & opb;
            AL_XOR:  res = opa ^ opb;
            default: res = opa + opb;
        endcase
    end

    assign trig   = (dec.dst_cls == RC_A) && (dec.dst != '0);
    assign hazard = trig
                 || (dec.a_cls == RC_X && dec.a_idx == pend_idx)
                 || (dec.b_sel == BS_X && dec.b_idx == pend_idx)
                 || (dec.dst_cls == RC_X && dec.dst == pend_idx);

    assign instr_ready = !(busy && hazard);
    assign accept      = instr_valid && instr_ready;
    assign x_we        = accept && dec.dst_cls == RC_X;
    assign a_we        = accept && dec.dst_cls == RC_A;
    assign b_we        = accept && dec.dst_cls == RC_B;
    assign start       = accept && trig;
    assign start_load  = (int'(dec.dst) <= LOAD_HI);
    assign mem_wdata   = xs;

    ldst_xfer_fsm #(.AW(AW), .DW(DW), .IW(XW)) u_fsm (
        .clk, .rst_n,
        .start, .start_load,
        .start_idx (dec.dst),
        .start_addr(res[AW-1:0]),
        .mem_rvalid, .mem_rdata,
        .busy, .pend_idx,
        .mem_req, .mem_we, .mem_addr,
        .fill_we, .fill_idx, .fill_data
    );

    // R7
    a0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.dst_cls == RC_A && dec.dst == '0 && !busy) |=> !mem_req);
    // R8
    b0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.a_cls == RC_B && dec.a_idx == '0) |-> (bj == '0));
    // R9
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> busy);

endmodule

// File: tb/sim_ldst_regunit.sv
module sim_ldst_regunit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int MEM_LAT    = 3;

    function automatic logic [29:0] enc_s(input logic [5:0] op, input logic [2:0] i, j, k);
        return {op, i, j, k, 15'b0};
    endfunction
    function automatic logic [29:0] enc_l(input logic [5:0] op, input logic [2:0] i, j, input logic [17:0] d);
        return {op, i, j, d};
    endfunction

    typedef struct packed {
        logic [29:0] s0;
        logic [29:0] s1;
        logic [29:0] op;
        logic [29:0] probe;
        logic [17:0] exp_addr;
        logic [59:0] exp_data;
        logic [7:0]  req;
    } vec_t;

    localparam logic [29:0] NOP = 30'h0;

    localparam vec_t TBL [0:9] = '{
        // R2 add with carry beyond 18 bits
        '{enc_l(6'h24,1,0,18'h3FFFF), enc_l(6'h24,2,0,18'h5), enc_s(6'h01,6,1,2),
          enc_l(6'h22,6,0,18'h40), 18'h40, 60'h40004, 8'd2},
        // R2 subtract below zero
        '{enc_l(6'h24,1,0,18'h1), enc_l(6'h24,2,0,18'h2), enc_s(6'h02,7,1,2),
          enc_l(6'h22,7,0,18'h41), 18'h41, 60'hFFFFFFFFFFFFFFF, 8'd2},
        // R2 xor
        '{enc_l(6'h24,3,0,18'h0F0F0), enc_l(6'h24,4,0,18'h3CC33), enc_s(6'h04,6,3,4),
          enc_l(6'h22,6,0,18'h42), 18'h42, 60'h33CC3, 8'd2},
        // R2 and
        '{NOP, NOP, enc_s(6'h03,7,3,4),
          enc_l(6'h22,7,0,18'h43), 18'h43, 60'h0C030, 8'd2},
        // R3 address displacement wraps, A0 has no side effect
        '{enc_l(6'h21,0,0,18'h3FFF0), NOP, enc_l(6'h21,7,0,18'h20),
          NOP, 18'h00010, 60'h0C030, 8'd3},
        // R3 index displacement wraps
        '{enc_l(6'h23,1,0,18'h3FFFF), enc_l(6'h23,2,1,18'h3), NOP,
          enc_l(6'h22,6,2,18'h10), 18'h12, 60'h33CC3, 8'd3},
        // R11 short index arithmetic
        '{NOP, enc_s(6'h06,3,1,2), enc_s(6'h05,7,0,3),
          NOP, 18'h3FFF1, 60'h0C030, 8'd11},
        // R8 write to B0 ignored
        '{enc_l(6'h23,0,1,18'h5), NOP, NOP,
          enc_l(6'h22,6,0,18'h44), 18'h44, 60'h33CC3, 8'd8},
        // R10 undefined opcode
        '{enc_l(6'h3F,6,1,18'h12345), enc_s(6'h17,6,1,2), NOP,
          enc_l(6'h22,6,0,18'h45), 18'h45, 60'h33CC3, 8'd10},
        // R5 load then use
        '{enc_l(6'h22,3,0,18'h40), enc_s(6'h01,6,3,0), NOP,
          enc_l(6'h22,6,0,18'h46), 18'h46, 60'h40004, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [29:0] instr_word = '0;
    logic        instr_ready, busy, mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [59:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [59:0] mem_rdata = '0;

    int nchk = 0, nfail = 0;
    int st_count = 0, req_count = 0;
    logic [17:0] last_addr;
    logic [59:0] last_data;
    logic [59:0] mem [256];
    int rsp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_regunit u0 (
        .clk, .rst_n, .instr_valid, .instr_word, .instr_ready, .busy,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata
    );

    // memory model
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            req_count <= req_count + 1;
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                last_addr <= mem_addr;
                last_data <= mem_wdata;
                st_count  <= st_count + 1;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
                rsp_cnt   <= MEM_LAT;
            end
        end else if (rsp_cnt > 0) begin
            rsp_cnt <= rsp_cnt - 1;
            if (rsp_cnt == 1) mem_rvalid <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [29:0] w, output int stalls);
        stalls = 0;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        #1;
        while (!instr_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int st;
        int sc;
        for (int a = 0; a < 256; a++) mem[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 mem_req", 64'(mem_req), 64'd0);
        check("R1 instr_ready", 64'(instr_ready), 64'd1);
        sc = st_count;
        issue(enc_l(6'h22, 7, 3, 18'h0), st);
        wait_idle();
        check("R1 store count", 64'(st_count - sc), 64'd1);
        check("R1 X7/B3 zero addr", 64'(last_addr), 64'd0);
        check("R1 X7 zero data", 64'(last_data), 64'd0);

        for (int e = 0; e < 10; e++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[e].req, e);
            sc = st_count;
            issue(TBL[e].s0, st);
            issue(TBL[e].s1, st);
            issue(TBL[e].op, st);
            issue(TBL[e].probe, st);
            wait_idle();
            check({tag, " count"}, 64'(st_count - sc), 64'd1);
            check({tag, " addr"}, 64'(last_addr), 64'(TBL[e].exp_addr));
            check({tag, " data"}, 64'(last_data), 64'(TBL[e].exp_data));
        end

        // R4 load request timing and address
        issue(enc_l(6'h22, 2, 0, 18'h41), st);
        @(negedge clk);
        check("R4 mem_req", 64'(mem_req), 64'd1);
        check("R4 mem_we", 64'(mem_we), 64'd0);
        check("R4 mem_addr", 64'(mem_addr), 64'h41);
        check("R4 busy", 64'(busy), 64'd1);
        // R5 filled X2 read back through X7 store
        issue(enc_s(6'h01, 7, 2, 0), st);
        issue(enc_l(6'h22, 7, 0, 18'h47), st);
        wait_idle();
        check("R5 load data", 64'(last_data), 64'hFFFFFFFFFFFFFFF);

        // R6 store request timing
        issue(enc_l(6'h22, 6, 0, 18'h48), st);
        @(negedge clk);
        check("R6 mem_req", 64'(mem_req), 64'd1);
        check("R6 mem_we", 64'(mem_we), 64'd1);
        check("R6 mem_addr", 64'(mem_addr), 64'h48);
        check("R6 mem_wdata", 64'(mem_wdata), 64'h40004);
        @(negedge clk);
        check("R6 busy end", 64'(busy), 64'd0);

        // R7 A0 write, no request
        sc = req_count;
        issue(enc_l(6'h21, 0, 0, 18'h1), st);
        repeat (4) @(negedge clk);
        check("R7 no request", 64'(req_count - sc), 64'd0);
        check("R7 busy", 64'(busy), 64'd0);

        // R9 hazard stalling
        issue(enc_l(6'h22, 4, 0, 18'h40), st);
        issue(enc_l(6'h24, 5, 0, 18'h7), st);
        check("R9 unrelated not stalled", 64'(st), 64'd0);
        issue(enc_s(6'h01, 6, 4, 0), st);
        check("R9 reader stalled", 64'(st > 0), 64'd1);
        issue(enc_l(6'h22, 6, 0, 18'h49), st);
        wait_idle();
        check("R9 data after stall", 64'(last_data), 64'h40004);
        issue(enc_l(6'h22, 1, 0, 18'h41), st);
        issue(enc_l(6'h22, 5, 0, 18'h40), st);
        check("R9 second trigger stalled", 64'(st > 0), 64'd1);
        wait_idle();
        issue(enc_s(6'h01, 7, 1, 0), st);
        issue(enc_l(6'h22, 7, 0, 18'h4A), st);
        wait_idle();
        check("R9 first load data", 64'(last_data), 64'hFFFFFFFFFFFFFFF);
        issue(enc_s(6'h01, 7, 5, 0), st);
        issue(enc_l(6'h22, 7, 0, 18'h4B), st);
        wait_idle();
        check("R9 second load data", 64'(last_data), 64'h40004);

        summary();
        $finish;
    end

endmodule